// File: doc/BRIEF.md
# Qualified Programmable Event Counter

This block is one performance-monitoring counter. Each clock cycle it sees a small per-cycle event count on each of several input lanes, plus the current privilege ring. A control register chooses one lane and decides how that lane's count is turned into an increment. The count can be added in full. It can instead be compared against a threshold, with the comparison optionally reversed. It can also be reduced to one count per false-to-true transition. Counting is further gated by the privilege ring and by a master enable.

Software reaches the block through a small register port with three registers: control, count and status. Writes are synchronous. Reads are combinational on the address. When the counter wraps past all-ones, a sticky overflow flag is set. The interrupt output then follows that flag whenever interrupts are enabled.

Top module: `evt_qual_counter`

## Requirements
- R1: With a threshold of zero, the counter adds the selected lane's full count in each qualifying cycle. The lane is chosen by control bits [2:0], and lane k occupies `evt_i[k*LANE_W +: LANE_W]`.
- R2: With a nonzero threshold in control bits [15:8], the counter adds exactly one in each qualifying cycle where the lane count is at least the threshold, and adds nothing otherwise.
- R3: With the invert bit (control bit 17) set and a nonzero threshold, the counter adds one where the lane count is below the threshold. With a zero threshold, the invert bit has no effect.
- R4: With the edge bit (control bit 16) set, the counter adds one only in a cycle where the qualified condition is true and was false in the previous cycle. For a zero threshold, the condition is "lane count is nonzero". The remembered previous condition clears at reset and on every control write.
- R5: The kernel enable (bit 19) admits ring 0 only (`priv_i` == 0). The user enable (bit 18) admits rings 1 to 3. When both bits are clear, every ring counts.
- R6: With the count enable (bit 20) clear, the counter does not move. A lane select at or above NUM_LANES reads as a zero count.
- R7: Register addresses are 0 for control, 1 for count and 2 for status. Control reads back its defined fields with the unused bits as zero. A count write loads the written value and overrides any increment in that same cycle.
- R8: A carry out of the counter sets the overflow flag (status bit 0). The flag stays set until a status write with bit 0 at one. A write of zero leaves it set. A wrap in the same cycle as a clear leaves the flag set.
- R9: `irq_o` is high exactly while the overflow flag is set and the interrupt enable (control bit 21) is set.
- R10: After reset, control, count and overflow all read zero and `irq_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_i | input | NUM_LANES*LANE_W | Per-cycle event counts, one field per lane |
| priv_i | input | 2 | Current privilege ring, 0 to 3 |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | DATA_W | Register write data |
| bus_rdata | output | DATA_W | Register read data for bus_addr |
| irq_o | output | 1 | Overflow interrupt |

## Verification
A corrupted control register appears on the very next read of address 0. It also appears within one cycle as a count that diverges from the bench's model. A stale edge-memory bit shows up as a missing or extra increment on the first true cycle after a control write, which makes the count wrong one cycle later. An overflow flag that is lost or set spuriously shows up in the status read and on `irq_o` in the cycle after the wrap. The bench compares all of these after every clock.

// File: rtl/evq_pkg.sv
`timescale 1ns/1ps
package evq_pkg;
   localparam int SEL_W     = 3;
   localparam int THR_W     = 8;
   localparam int MAX_LANES = 1 << SEL_W;

   localparam int SEL_LSB   = 0;
   localparam int THR_LSB   = 8;
   localparam int EDGE_BIT  = 16;
   localparam int INV_BIT   = 17;
   localparam int USR_BIT   = 18;
   localparam int KRN_BIT   = 19;
   localparam int EN_BIT    = 20;
   localparam int IRQ_BIT   = 21;
   localparam int CTRL_USED = 22;

   typedef enum logic [1:0] {
      REG_CTRL   = 2'd0,
      REG_COUNT  = 2'd1,
      REG_STATUS = 2'd2,
      REG_NONE   = 2'd3
   } reg_addr_e;

   typedef struct packed {
      logic             irq_en;
      logic             cnt_en;
      logic             krn_en;
      logic             usr_en;
      logic             inv;
      logic             edge_en;
      logic [THR_W-1:0] thr;
      logic [SEL_W-1:0] sel;
   } ctrl_t;

   function automatic ctrl_t ctrl_unpack(input logic [CTRL_USED-1:0] w);
      ctrl_t c;
      c.sel     = w[SEL_LSB +: SEL_W];
      c.thr     = w[THR_LSB +: THR_W];
      c.edge_en = w[EDGE_BIT];
      c.inv     = w[INV_BIT];
      c.usr_en  = w[USR_BIT];
      c.krn_en  = w[KRN_BIT];
      c.cnt_en  = w[EN_BIT];
      c.irq_en  = w[IRQ_BIT];
      return c;
   endfunction

   function automatic logic [CTRL_USED-1:0] ctrl_pack(input ctrl_t c);
      logic [CTRL_USED-1:0] w;
      w = '0;
      w[SEL_LSB +: SEL_W] = c.sel;
      w[THR_LSB +: THR_W] = c.thr;
      w[EDGE_BIT]         = c.edge_en;
      w[INV_BIT]          = c.inv;
      w[USR_BIT]          = c.usr_en;
      w[KRN_BIT]          = c.krn_en;
      w[EN_BIT]           = c.cnt_en;
      w[IRQ_BIT]          = c.irq_en;
      return w;
   endfunction
endpackage

// File: rtl/evq_regs.sv
`timescale 1ns/1ps
module evq_regs
   import evq_pkg::*;
#(
   parameter int DATA_W = 64,
   parameter int CNT_W  = 48
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [1:0]        bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic [CNT_W-1:0]  cnt_q,
   input  logic              ovf_q,
   output ctrl_t             ctrl_q,
   output logic              ctrl_wr,
   output logic              cnt_wr,
   output logic              stat_clr,
   output logic [DATA_W-1:0] bus_rdata
);
   reg_addr_e addr;
   assign addr = reg_addr_e'(bus_addr);

   // write decode
   assign ctrl_wr  = bus_we && (addr == REG_CTRL);
   assign cnt_wr   = bus_we && (addr == REG_COUNT);
   assign stat_clr = bus_we && (addr == REG_STATUS) && bus_wdata[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ctrl_q <= '0;
      else if (ctrl_wr) ctrl_q <= ctrl_unpack(bus_wdata[CTRL_USED-1:0]);
   end

   // read mux
   always_comb begin
      unique case (addr)
         REG_CTRL:   bus_rdata = DATA_W'(ctrl_pack(ctrl_q));
         REG_COUNT:  bus_rdata = DATA_W'(cnt_q);
         REG_STATUS: bus_rdata = DATA_W'(ovf_q);
         default:    bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/evq_qual.sv
`timescale 1ns/1ps
module evq_qual
   import evq_pkg::*;
#(
   parameter int NUM_LANES = 8,
   parameter int LANE_W    = 3
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [NUM_LANES*LANE_W-1:0]   evt_i,
   input  logic [1:0]                    priv_i,
   input  ctrl_t                         ctrl_q,
   input  logic                          ctrl_wr,
   output logic [LANE_W-1:0]             incr_o
);
   // lane table padded to the full select range; missing lanes read zero
   logic [LANE_W-1:0] lane_tbl [MAX_LANES];

   for (genvar g = 0; g < MAX_LANES; g++) begin : g_lane
      if (g < NUM_LANES) begin : g_live
         assign lane_tbl[g] = evt_i[g*LANE_W +: LANE_W];
      end else begin : g_pad
         assign lane_tbl[g] = '0;
      end
   end

   logic [LANE_W-1:0] lane;
   logic [THR_W-1:0]  lane_ext;
   logic              thr_zero, cond, ring0, priv_ok, gate, qual, prev_q;

   assign lane     = lane_tbl[ctrl_q.sel];
   assign lane_ext = THR_W'(lane);
   assign thr_zero = (ctrl_q.thr == '0);
   assign cond     = thr_zero ? (lane != '0) : ((lane_ext >= ctrl_q.thr) ^ ctrl_q.inv);
   assign ring0    = (priv_i == 2'd0);
   assign priv_ok  = (!ctrl_q.usr_en && !ctrl_q.krn_en)
                   || (ctrl_q.krn_en && ring0)
                   || (ctrl_q.usr_en && !ring0);
   assign gate     = ctrl_q.cnt_en && priv_ok;
   assign qual     = cond && gate;

   // previous qualified condition for edge mode
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       prev_q <= 1'b0;
      else if (ctrl_wr) prev_q <= 1'b0;
      else              prev_q <= qual;
   end

   always_comb begin
      if (!gate)               incr_o = '0;
      else if (ctrl_q.edge_en) incr_o = LANE_W'(qual && !prev_q);
      else if (thr_zero)       incr_o = lane;
      else                     incr_o = LANE_W'(cond);
   end
endmodule

// File: rtl/evq_accum.sv
`timescale 1ns/1ps
module evq_accum #(
   parameter int CNT_W = 48,
   parameter int INC_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [INC_W-1:0] incr_i,
   input  logic             cnt_wr,
   input  logic [CNT_W-1:0] wr_val,
   input  logic             stat_clr,
   output logic [CNT_W-1:0] cnt_q,
   output logic             ovf_q
);
   logic [CNT_W:0] sum;
   logic           wrap;

   assign sum  = {1'b0, cnt_q} + (CNT_W+1)'(incr_i);
   assign wrap = sum[CNT_W] && !cnt_wr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (cnt_wr) cnt_q <= wr_val;
      else             cnt_q <= sum[CNT_W-1:0];
   end

   // set wins over a same-cycle clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        ovf_q <= 1'b0;
      else if (wrap)     ovf_q <= 1'b1;
      else if (stat_clr) ovf_q <= 1'b0;
   end
endmodule

// File: rtl/evt_qual_counter.sv
`timescale 1ns/1ps
module evt_qual_counter
   import evq_pkg::*;
#(
   parameter int NUM_LANES = 8,
   parameter int LANE_W    = 3,
   parameter int CNT_W     = 48,
   parameter int DATA_W    = 64
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NUM_LANES*LANE_W-1:0] evt_i,
   input  logic [1:0]                  priv_i,
   input  logic                        bus_we,
   input  logic [1:0]                  bus_addr,
   input  logic [DATA_W-1:0]           bus_wdata,
   output logic [DATA_W-1:0]           bus_rdata,
   output logic                        irq_o
);
   if (NUM_LANES < 1 || NUM_LANES > MAX_LANES) begin : g_bad_lanes
      $error("NUM_LANES out of range");
   end
   if (LANE_W < 1 || LANE_W > THR_W || LANE_W >= CNT_W) begin : g_bad_lane_w
      $error("LANE_W out of range");
   end
   if (DATA_W < CNT_W || DATA_W < CTRL_USED) begin : g_bad_data_w
      $error("DATA_W too narrow");
   end

   ctrl_t             ctrl_q;
   logic              ctrl_wr, cnt_wr, stat_clr, ovf_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [LANE_W-1:0] incr;

   evq_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .cnt_q(cnt_q), .ovf_q(ovf_q), .ctrl_q(ctrl_q),
      .ctrl_wr(ctrl_wr), .cnt_wr(cnt_wr), .stat_clr(stat_clr),
      .bus_rdata(bus_rdata)
   );

   evq_qual #(.NUM_LANES(NUM_LANES), .LANE_W(LANE_W)) u_qual (
      .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .priv_i(priv_i),
      .ctrl_q(ctrl_q), .ctrl_wr(ctrl_wr), .incr_o(incr)
   );

   evq_accum #(.CNT_W(CNT_W), .INC_W(LANE_W)) u_accum (
      .clk(clk), .rst_n(rst_n), .incr_i(incr), .cnt_wr(cnt_wr),
      .wr_val(bus_wdata[CNT_W-1:0]), .stat_clr(stat_clr),
      .cnt_q(cnt_q), .ovf_q(ovf_q)
   );

   assign irq_o = ovf_q && ctrl_q.irq_en;
endmodule

// File: rtl/evq_checker.sv
`timescale 1ns/1ps
module evq_checker #(
   parameter int CNT_W = 48
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cnt_wr,
   input logic             stat_clr,
   input logic [CNT_W-1:0] cnt_q,
   input logic [CNT_W-1:0] wr_val,
   input logic             ovf_q,
   input logic             irq_o,
   input logic             thr_nz,
   input logic             edge_en,
   input logic             cnt_en
);
   logic [CNT_W-1:0] cnt_d, cnt_delta;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_d <= '0;
      else        cnt_d <= cnt_q;
   end
   assign cnt_delta = cnt_q - cnt_d;

   a_r7_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_wr |=> (cnt_q == $past(wr_val)));

   a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!cnt_en && !cnt_wr) |=> $stable(cnt_q));

   a_r2_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
      (thr_nz && !cnt_wr) |=> (cnt_delta <= CNT_W'(1)));

   a_r4_edge_step: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_en && !cnt_wr) |=> (cnt_delta <= CNT_W'(1)));

   a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_q && !stat_clr) |=> ovf_q);

   a_r8_wrap_flags: assert property (@(posedge clk) disable iff (!rst_n)
      !cnt_wr |=> ((cnt_q >= cnt_d) || ovf_q));

   a_r9_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> ovf_q);
endmodule

bind evt_qual_counter evq_checker #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cnt_wr(cnt_wr), .stat_clr(stat_clr),
   .cnt_q(cnt_q), .wr_val(bus_wdata[CNT_W-1:0]), .ovf_q(ovf_q),
   .irq_o(irq_o), .thr_nz(ctrl_q.thr != '0), .edge_en(ctrl_q.edge_en),
   .cnt_en(ctrl_q.cnt_en)
);

// File: tb/tb_evt_qual_counter.sv
`timescale 1ns/1ps
module tb_evt_qual_counter;
   localparam int NL = 6;
   localparam int LW = 3;
   localparam int CW = 48;
   localparam int DW = 64;
   localparam longint unsigned MASK = (64'd1 << CW) - 64'd1;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [NL*LW-1:0] evt = '0;
   logic [1:0]      priv = '0;
   logic            bus_we = 1'b0;
   logic [1:0]      bus_addr = '0;
   logic [DW-1:0]   bus_wdata = '0;
   logic [DW-1:0]   bus_rdata;
   logic            irq;

   int vectors = 0;
   int fails = 0;
   bit done = 0;

   // model state
   longint unsigned m_cnt = 0;
   longint unsigned m_ctrl_word = 0;
   bit m_ovf = 0, m_prev = 0;
   int m_sel = 0, m_thr = 0;
   bit m_edge = 0, m_inv = 0, m_usr = 0, m_krn = 0, m_en = 0, m_irq = 0;

   always #2 clk = ~clk;

   evt_qual_counter #(.NUM_LANES(NL), .LANE_W(LW), .CNT_W(CW), .DATA_W(DW)) dut (
      .clk(clk), .rst_n(rst_n), .evt_i(evt), .priv_i(priv), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq_o(irq)
   );

   function automatic logic [63:0] mk_ctrl(input int sel, input int thr,
      input bit edg, input bit inv, input bit usr, input bit krn,
      input bit en, input bit irqen);
      logic [63:0] w;
      w = 64'(sel & 7) | (64'(thr & 255) << 8) | (64'(edg) << 16) |
          (64'(inv) << 17) | (64'(usr) << 18) | (64'(krn) << 19) |
          (64'(en) << 20) | (64'(irqen) << 21);
      return w;
   endfunction

   function automatic logic [NL*LW-1:0] ev_one(input int idx, input int val);
      logic [NL*LW-1:0] e;
      e = '0;
      e[idx*LW +: LW] = LW'(val);
      return e;
   endfunction

   task automatic chk(input string tag, input string what,
                      input longint unsigned got, input longint unsigned exp);
      vectors++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
      end
   endtask

   task automatic check_all(input string tag);
      bus_addr = 2'd0; #0.2;
      chk(tag, "ctrl", bus_rdata, m_ctrl_word);
      bus_addr = 2'd1; #0.2;
      chk(tag, "count", bus_rdata, m_cnt);
      bus_addr = 2'd2; #0.2;
      chk(tag, "status", bus_rdata, {63'd0, m_ovf});
      chk(tag, "irq", {63'd0, irq}, {63'd0, m_ovf && m_irq});
   endtask

   // advance the model by one clock, from the requirements
   task automatic model_update(input logic [NL*LW-1:0] ev, input logic [1:0] pv,
                               input bit we, input logic [1:0] ad, input logic [63:0] wd);
      int lane;
      bit tz, cond, ring0, pok, gate, nprev, setf;
      longint unsigned inc, sum;
      lane  = (m_sel < NL) ? int'(ev[m_sel*LW +: LW]) : 0;
      tz    = (m_thr == 0);
      cond  = tz ? (lane != 0) : (m_inv ? (lane < m_thr) : (lane >= m_thr));
      ring0 = (pv == 2'd0);
      pok   = (!m_usr && !m_krn) || (m_krn && ring0) || (m_usr && !ring0);
      gate  = m_en && pok;
      if (!gate)       inc = 0;
      else if (m_edge) inc = (cond && !m_prev) ? 1 : 0;
      else if (tz)     inc = longint'(lane);
      else             inc = cond ? 1 : 0;
      nprev = cond && gate;
      setf  = 0;
      if (we && ad == 2'd1) m_cnt = wd & MASK;
      else begin
         sum = m_cnt + inc;
         if (sum > MASK) setf = 1;
         m_cnt = sum & MASK;
      end
      if (we && ad == 2'd2 && wd[0]) m_ovf = 0;
      if (setf) m_ovf = 1;
      if (we && ad == 2'd0) begin
         m_ctrl_word = wd & 64'h3FFF07;
         m_sel = int'(wd[2:0]);  m_thr = int'(wd[15:8]);
         m_edge = wd[16]; m_inv = wd[17]; m_usr = wd[18];
         m_krn = wd[19];  m_en = wd[20];  m_irq = wd[21];
         m_prev = 0;
      end else m_prev = nprev;
   endtask

   task automatic step(input logic [NL*LW-1:0] ev, input logic [1:0] pv,
                       input bit we, input logic [1:0] ad, input logic [63:0] wd,
                       input string tag);
      evt = ev; priv = pv; bus_we = we; bus_addr = ad; bus_wdata = wd;
      model_update(ev, pv, we, ad, wd);
      @(posedge clk);
      @(negedge clk);
      bus_we = 1'b0;
      check_all(tag);
   endtask

   task automatic run(input logic [NL*LW-1:0] ev, input logic [1:0] pv, input string tag);
      step(ev, pv, 1'b0, 2'd3, 64'd0, tag);
   endtask

   task automatic wr(input logic [1:0] ad, input logic [63:0] wd, input string tag);
      step('0, 2'd0, 1'b1, ad, wd, tag);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd7321));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      check_all("R10");

      // R1: full count at zero threshold, lane 2
      wr(2'd0, mk_ctrl(2, 0, 0, 0, 0, 0, 1, 0), "R1");
      run(ev_one(2, 5) | ev_one(0, 7), 2'd1, "R1");
      run(ev_one(2, 7), 2'd0, "R1");
      run(ev_one(1, 6), 2'd3, "R1");
      run(ev_one(2, 3), 2'd2, "R1");

      // R2: threshold four
      wr(2'd0, mk_ctrl(2, 4, 0, 0, 0, 0, 1, 0), "R2");
      run(ev_one(2, 3), 2'd0, "R2");
      run(ev_one(2, 4), 2'd0, "R2");
      run(ev_one(2, 7), 2'd0, "R2");
      run(ev_one(2, 5), 2'd0, "R2");

      // R3: inverted threshold, then invert with zero threshold
      wr(2'd0, mk_ctrl(2, 4, 0, 1, 0, 0, 1, 0), "R3");
      run(ev_one(2, 3), 2'd0, "R3");
      run(ev_one(2, 0), 2'd0, "R3");
      run(ev_one(2, 4), 2'd0, "R3");
      wr(2'd0, mk_ctrl(2, 0, 0, 1, 0, 0, 1, 0), "R3");
      run(ev_one(2, 6), 2'd0, "R3");
      run(ev_one(2, 0), 2'd0, "R3");

      // R4: edge with threshold one, then control write while true
      wr(2'd0, mk_ctrl(1, 1, 1, 0, 0, 0, 1, 0), "R4");
      run(ev_one(1, 2), 2'd0, "R4");
      run(ev_one(1, 2), 2'd0, "R4");
      run(ev_one(1, 2), 2'd0, "R4");
      run(ev_one(1, 0), 2'd0, "R4");
      run(ev_one(1, 3), 2'd0, "R4");
      step(ev_one(1, 3), 2'd0, 1'b1, 2'd0, mk_ctrl(1, 1, 1, 0, 0, 0, 1, 0), "R4");
      run(ev_one(1, 3), 2'd0, "R4");
      run(ev_one(1, 3), 2'd0, "R4");

      // R5: privilege gating
      wr(2'd0, mk_ctrl(0, 0, 0, 0, 0, 1, 1, 0), "R5");
      run(ev_one(0, 4), 2'd0, "R5");
      run(ev_one(0, 4), 2'd2, "R5");
      wr(2'd0, mk_ctrl(0, 0, 0, 0, 1, 0, 1, 0), "R5");
      run(ev_one(0, 4), 2'd0, "R5");
      run(ev_one(0, 4), 2'd3, "R5");
      wr(2'd0, mk_ctrl(0, 0, 0, 0, 0, 0, 1, 0), "R5");
      run(ev_one(0, 2), 2'd0, "R5");
      run(ev_one(0, 2), 2'd1, "R5");

      // R6: enable clear, out-of-range select, last lane
      wr(2'd0, mk_ctrl(0, 0, 0, 0, 0, 0, 0, 0), "R6");
      run(ev_one(0, 7), 2'd0, "R6");
      wr(2'd0, mk_ctrl(7, 0, 0, 0, 0, 0, 1, 0), "R6");
      run('1, 2'd0, "R6");
      wr(2'd0, mk_ctrl(5, 0, 0, 0, 0, 0, 1, 0), "R6");
      run(ev_one(5, 6), 2'd0, "R6");

      // R7: count write beats a same-cycle increment
      step(ev_one(5, 7), 2'd0, 1'b1, 2'd1, 64'd100, "R7");
      run(ev_one(5, 1), 2'd0, "R7");

      // R8: wrap, sticky flag, clear, set-wins
      wr(2'd0, mk_ctrl(0, 0, 0, 0, 0, 0, 1, 0), "R8");
      wr(2'd1, MASK - 64'd1, "R8");
      run(ev_one(0, 3), 2'd0, "R8");
      wr(2'd2, 64'd0, "R8");
      wr(2'd2, 64'd1, "R8");
      wr(2'd1, MASK, "R8");
      step(ev_one(0, 1), 2'd0, 1'b1, 2'd2, 64'd1, "R8");

      // R9: interrupt follows the enable while the flag is set
      wr(2'd0, mk_ctrl(0, 0, 0, 0, 0, 0, 1, 1), "R9");
      run('0, 2'd0, "R9");
      wr(2'd2, 64'd1, "R9");

      // constrained random
      for (int i = 0; i < 2500; i++) begin
         int unsigned r;
         logic [NL*LW-1:0] ev;
         r  = $urandom % 64;
         ev = NL*LW'($urandom);
         if (r < 4)
            step(ev, 2'($urandom), 1'b1, 2'd0,
                 mk_ctrl(int'($urandom % 8), ($urandom % 3 == 0) ? 0 : int'($urandom % 8),
                         1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                         ($urandom % 5) != 0, 1'($urandom)), "R2 random");
         else if (r < 6)
            step(ev, 2'($urandom), 1'b1, 2'd1, MASK - 64'($urandom % 12), "R8 random");
         else if (r < 8)
            step(ev, 2'($urandom), 1'b1, 2'd2, 64'($urandom % 2), "R8 random");
         else
            run(ev, 2'($urandom), "R1 random");
      end

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule